// File: doc/BRIEF.md
# Raster Sync and Display-Enable Timing Generator

This block produces the horizontal and vertical sync pulses, the display-enable window and the pixel and line position counters for a raster display. It runs from the pixel clock and advances one pixel per cycle. A set of configuration inputs gives the frame geometry. Horizontal quantities are in units of 8 pixels, biased by minus one. Vertical quantities are in lines, biased by minus one. Each direction is described by four values: the active length, the blanking length after the active region, the delay from the end of active video to the start of sync, and the sync width. A polarity bit per direction and a blank bit complete the set.

The configuration inputs are copied into a shadow register only at the frame boundary, so a frame never mixes two timings. After reset the shadow holds parameter defaults. Those defaults are a 640x480 frame with 800 pixels per line and 525 lines, using a 96-pixel hsync, a 2-line vsync and a 10-line vertical front porch. A status output reports when the raster is in the vertical non-display period.

Top module: `raster_timing`

## Requirements
- R1: The pixel counter `x` counts 0,1,2,... and returns to 0 after the value 8*(HACT+1) + 8*(HBLANK+1) - 1. HACT and HBLANK are the shadow values of `cfg_hact` and `cfg_hblank`.
- R2: The line counter `y` advances by one in the cycle after `x` returns to 0. It returns to 0 after line (VACT+1) + (VBLANK+1) - 1.
- R3: Horizontal sync is active for pixels x in [A + 8*(HSDLY+1), A + 8*(HSDLY+1) + 8*(HSWID+1)), where A = 8*(HACT+1). Any part of that window past the end of the line never occurs.
- R4: Vertical sync is active for lines y in [L + VSDLY+1, L + VSDLY+1 + VSWID+1), where L = VACT+1. Any part of that window past the end of the frame never occurs.
- R5: A polarity bit of 1 drives the sync output high when the sync is active and low otherwise. A polarity bit of 0 gives the inverse levels.
- R6: `de` is 1 exactly when x < 8*(HACT+1), y < VACT+1 and the shadow blank bit is 0.
- R7: With the shadow blank bit set, `de` stays 0 while `hsync`, `vsync`, `x` and `y` keep their normal sequence.
- R8: `vretrace` is 1 exactly when y >= VACT+1.
- R9: The shadow takes all configuration inputs in the cycle where x and y both return to 0. Input changes made at any other time have no effect on the outputs until that point.
- R10: While `rst_n` is low, x = 0 and y = 0, and the shadow holds the reset-parameter configuration with the blank bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_hact | input | HCW | Active pixels / 8, minus one |
| cfg_hblank | input | HCW | Horizontal blanking pixels / 8, minus one |
| cfg_hsdly | input | HCW | Hsync start after active end, in 8-pixel units minus one |
| cfg_hswid | input | HCW | Hsync width / 8, minus one |
| cfg_hspol | input | 1 | Hsync polarity (1 = active high) |
| cfg_vact | input | VW | Active lines minus one |
| cfg_vblank | input | VW | Vertical blanking lines minus one |
| cfg_vsdly | input | VW | Vsync start after the last active line, in lines minus one |
| cfg_vswid | input | VW | Vsync width in lines minus one |
| cfg_vspol | input | 1 | Vsync polarity (1 = active high) |
| cfg_blank | input | 1 | Force display enable low |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Display enable |
| x | output | HCW+4 | Pixel position in the line |
| y | output | VW+1 | Line position in the frame |
| vretrace | output | 1 | Vertical non-display status |

## Verification
A wrong pixel count shows on `x` within one line, and it shifts `hsync` and `de` in that same line. A wrong line count or a wrong vertical sync window shows on `y`, `vsync` or `vretrace` within one frame. A shadow load at the wrong time makes a line end at the new length while the frame is still running. The next cycle-level comparison against the reference model catches it. Configurations are changed at random points in the frame, which exposes early loading. Directed cases cover the smallest geometry, a sync window that runs past the line end, both polarities and the blank bit.

// File: rtl/raster_pkg.sv
package raster_pkg;

   typedef enum logic {
      POL_LOW  = 1'b0,
      POL_HIGH = 1'b1
   } sync_pol_e;

   // drive the external level of a sync pulse from its internal "on" state
   function automatic logic sync_level(input logic on, input sync_pol_e pol);
      return (pol == POL_HIGH) ? on : ~on;
   endfunction

endpackage

// File: rtl/raster_shadow.sv
module raster_shadow #(
   parameter int            W       = 8,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n)    q <= RST_VAL;
      else if (load) q <= d;
   end

endmodule

// File: rtl/raster_axis.sv
module raster_axis #(
   parameter  int FW = 8,            // width of each programmed field
   parameter  int SH = 3,            // log2 of the unit size (3: 8 pixels, 0: lines)
   localparam int CW = FW + SH + 1,  // counter width
   localparam int EW = FW + SH + 2   // width for sync window arithmetic
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic [FW-1:0] act_m1,
   input  logic [FW-1:0] blk_m1,
   input  logic [FW-1:0] sdly_m1,
   input  logic [FW-1:0] swid_m1,
   output logic [CW-1:0] cnt,
   output logic          last,
   output logic          in_act,
   output logic          sync_on
);

   logic [EW-1:0] act_len, blk_len, sdly_len, swid_len;
   logic [EW-1:0] tot_len, s_beg, s_end, cnt_x;

   generate
      if (SH == 0) begin : g_unit_line
         assign act_len  = {{(EW-FW){1'b0}}, act_m1}  + EW'(1);
         assign blk_len  = {{(EW-FW){1'b0}}, blk_m1}  + EW'(1);
         assign sdly_len = {{(EW-FW){1'b0}}, sdly_m1} + EW'(1);
         assign swid_len = {{(EW-FW){1'b0}}, swid_m1} + EW'(1);
      end else begin : g_unit_char
         assign act_len  = ({{(EW-FW){1'b0}}, act_m1}  + EW'(1)) << SH;
         assign blk_len  = ({{(EW-FW){1'b0}}, blk_m1}  + EW'(1)) << SH;
         assign sdly_len = ({{(EW-FW){1'b0}}, sdly_m1} + EW'(1)) << SH;
         assign swid_len = ({{(EW-FW){1'b0}}, swid_m1} + EW'(1)) << SH;
      end
   endgenerate

   assign cnt_x   = {1'b0, cnt};
   assign tot_len = act_len + blk_len;
   assign s_beg   = act_len + sdly_len;
   assign s_end   = s_beg + swid_len;

   assign last    = (cnt_x == tot_len - EW'(1));
   assign in_act  = (cnt_x < act_len);
   assign sync_on = (cnt_x >= s_beg) && (cnt_x < s_end);

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (step) cnt <= last ? '0 : cnt + CW'(1);
   end

endmodule

// File: rtl/raster_timing.sv
module raster_timing
   import raster_pkg::*;
#(
   parameter  int HCW        = 8,
   parameter  int VW         = 10,
   parameter  int RST_HACT   = 79,
   parameter  int RST_HBLANK = 19,
   parameter  int RST_HSDLY  = 1,
   parameter  int RST_HSWID  = 11,
   parameter  int RST_HSPOL  = 0,
   parameter  int RST_VACT   = 479,
   parameter  int RST_VBLANK = 44,
   parameter  int RST_VSDLY  = 9,
   parameter  int RST_VSWID  = 1,
   parameter  int RST_VSPOL  = 0,
   localparam int XW         = HCW + 4,
   localparam int YW         = VW + 1,
   localparam int CFGW       = 4 * HCW + 4 * VW + 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [HCW-1:0] cfg_hact,
   input  logic [HCW-1:0] cfg_hblank,
   input  logic [HCW-1:0] cfg_hsdly,
   input  logic [HCW-1:0] cfg_hswid,
   input  logic           cfg_hspol,
   input  logic [VW-1:0]  cfg_vact,
   input  logic [VW-1:0]  cfg_vblank,
   input  logic [VW-1:0]  cfg_vsdly,
   input  logic [VW-1:0]  cfg_vswid,
   input  logic           cfg_vspol,
   input  logic           cfg_blank,
   output logic           hsync,
   output logic           vsync,
   output logic           de,
   output logic [XW-1:0]  x,
   output logic [YW-1:0]  y,
   output logic           vretrace
);

   // elaboration-time parameter checks
   if (HCW < 1 || VW < 1) begin : g_bad_width
      $error("raster_timing: field widths must be at least 1");
   end
   if (RST_HACT >= (1 << HCW) || RST_HBLANK >= (1 << HCW) ||
       RST_HSDLY >= (1 << HCW) || RST_HSWID >= (1 << HCW)) begin : g_bad_hrst
      $error("raster_timing: horizontal reset value does not fit HCW");
   end
   if (RST_VACT >= (1 << VW) || RST_VBLANK >= (1 << VW) ||
       RST_VSDLY >= (1 << VW) || RST_VSWID >= (1 << VW)) begin : g_bad_vrst
      $error("raster_timing: vertical reset value does not fit VW");
   end
   if (RST_HSPOL > 1 || RST_VSPOL > 1) begin : g_bad_pol
      $error("raster_timing: polarity reset value must be 0 or 1");
   end

   localparam logic [CFGW-1:0] RST_CFG = {
      1'b0, 1'(RST_VSPOL), 1'(RST_HSPOL),
      VW'(RST_VSWID), VW'(RST_VSDLY), VW'(RST_VBLANK), VW'(RST_VACT),
      HCW'(RST_HSWID), HCW'(RST_HSDLY), HCW'(RST_HBLANK), HCW'(RST_HACT)
   };

   logic [CFGW-1:0] cfg_in, sh_cfg;
   logic [HCW-1:0]  sh_hact, sh_hblank, sh_hsdly, sh_hswid;
   logic [VW-1:0]   sh_vact, sh_vblank, sh_vsdly, sh_vswid;
   logic            sh_hspol, sh_vspol, sh_blank;
   logic            h_last, h_in_act, h_sync_on;
   logic            v_last, v_in_act, v_sync_on;
   logic            frame_end;

   assign cfg_in = {cfg_blank, cfg_vspol, cfg_hspol,
                    cfg_vswid, cfg_vsdly, cfg_vblank, cfg_vact,
                    cfg_hswid, cfg_hsdly, cfg_hblank, cfg_hact};

   assign frame_end = h_last & v_last;

   raster_shadow #(.W(CFGW), .RST_VAL(RST_CFG)) u_shadow (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (frame_end),
      .d     (cfg_in),
      .q     (sh_cfg)
   );

   assign {sh_blank, sh_vspol, sh_hspol,
           sh_vswid, sh_vsdly, sh_vblank, sh_vact,
           sh_hswid, sh_hsdly, sh_hblank, sh_hact} = sh_cfg;

   raster_axis #(.FW(HCW), .SH(3)) u_haxis (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (1'b1),
      .act_m1  (sh_hact),
      .blk_m1  (sh_hblank),
      .sdly_m1 (sh_hsdly),
      .swid_m1 (sh_hswid),
      .cnt     (x),
      .last    (h_last),
      .in_act  (h_in_act),
      .sync_on (h_sync_on)
   );

   raster_axis #(.FW(VW), .SH(0)) u_vaxis (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (h_last),
      .act_m1  (sh_vact),
      .blk_m1  (sh_vblank),
      .sdly_m1 (sh_vsdly),
      .swid_m1 (sh_vswid),
      .cnt     (y),
      .last    (v_last),
      .in_act  (v_in_act),
      .sync_on (v_sync_on)
   );

   assign hsync    = sync_level(h_sync_on, sync_pol_e'(sh_hspol));
   assign vsync    = sync_level(v_sync_on, sync_pol_e'(sh_vspol));
   assign de       = h_in_act & v_in_act & ~sh_blank;
   assign vretrace = ~v_in_act;

endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
   parameter int XW   = 12,
   parameter int YW   = 11,
   parameter int CFGW = 75
) (
   input logic            clk,
   input logic            rst_n,
   input logic [XW-1:0]   x,
   input logic [YW-1:0]   y,
   input logic            hsync,
   input logic            de,
   input logic            vretrace,
   input logic            h_in_act,
   input logic            sh_hspol,
   input logic            sh_blank,
   input logic [CFGW-1:0] sh_cfg
);

   // R1: away from the wrap the pixel counter moves by exactly one
   p_x_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (x != '0) |-> (x == $past(x) + 1'b1));

   // R2: the line counter changes only when the pixel counter wraps
   p_y_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (x != '0) |-> $stable(y));

   // R5: during active pixels hsync rests at its inactive level
   p_hidle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      h_in_act |-> (hsync == !sh_hspol));

   // R6: display enable never overlaps vertical retrace
   p_de_act_r6: assert property (@(posedge clk) disable iff (!rst_n)
      de |-> !vretrace);

   // R7: blank forces display enable low
   p_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sh_blank |-> !de);

   // R9: the shadow configuration changes only at the frame origin
   p_cfg_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((x != '0) || (y != '0)) |-> $stable(sh_cfg));

endmodule

bind raster_timing raster_timing_chk #(.XW(XW), .YW(YW), .CFGW(CFGW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .x        (x),
   .y        (y),
   .hsync    (hsync),
   .de       (de),
   .vretrace (vretrace),
   .h_in_act (h_in_act),
   .sh_hspol (sh_hspol),
   .sh_blank (sh_blank),
   .sh_cfg   (sh_cfg)
);

// File: tb/raster_timing_bench.sv
module raster_timing_bench;

   localparam int HCW = 4;
   localparam int VW  = 4;
   localparam int XW  = HCW + 4;
   localparam int YW  = VW + 1;

   localparam int R_HACT = 1, R_HBLANK = 1, R_HSDLY = 0, R_HSWID = 0, R_HSPOL = 1;
   localparam int R_VACT = 3, R_VBLANK = 3, R_VSDLY = 0, R_VSWID = 0, R_VSPOL = 1;

   localparam int WATCHDOG_CYCLES = 200000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [HCW-1:0] cfg_hact, cfg_hblank, cfg_hsdly, cfg_hswid;
   logic [VW-1:0]  cfg_vact, cfg_vblank, cfg_vsdly, cfg_vswid;
   logic           cfg_hspol, cfg_vspol, cfg_blank;
   logic           hsync, vsync, de, vretrace;
   logic [XW-1:0]  x;
   logic [YW-1:0]  y;

   raster_timing #(
      .HCW(HCW), .VW(VW),
      .RST_HACT(R_HACT), .RST_HBLANK(R_HBLANK), .RST_HSDLY(R_HSDLY),
      .RST_HSWID(R_HSWID), .RST_HSPOL(R_HSPOL),
      .RST_VACT(R_VACT), .RST_VBLANK(R_VBLANK), .RST_VSDLY(R_VSDLY),
      .RST_VSWID(R_VSWID), .RST_VSPOL(R_VSPOL)
   ) u_raster_timing (
      .clk(clk), .rst_n(rst_n),
      .cfg_hact(cfg_hact), .cfg_hblank(cfg_hblank), .cfg_hsdly(cfg_hsdly),
      .cfg_hswid(cfg_hswid), .cfg_hspol(cfg_hspol),
      .cfg_vact(cfg_vact), .cfg_vblank(cfg_vblank), .cfg_vsdly(cfg_vsdly),
      .cfg_vswid(cfg_vswid), .cfg_vspol(cfg_vspol), .cfg_blank(cfg_blank),
      .hsync(hsync), .vsync(vsync), .de(de), .x(x), .y(y), .vretrace(vretrace)
   );

   typedef struct {
      int ha, hb, hd, hw, hp;
      int va, vb, vd, vw, vp;
      int bl;
   } mcfg_t;

   int    checks = 0;
   int    errors = 0;
   bit    done   = 1'b0;
   bit    mon_en = 1'b0;
   int    mx, my;
   mcfg_t msh;

   function automatic mcfg_t rst_cfg();
      mcfg_t c;
      c.ha = R_HACT; c.hb = R_HBLANK; c.hd = R_HSDLY; c.hw = R_HSWID; c.hp = R_HSPOL;
      c.va = R_VACT; c.vb = R_VBLANK; c.vd = R_VSDLY; c.vw = R_VSWID; c.vp = R_VSPOL;
      c.bl = 0;
      return c;
   endfunction

   function automatic mcfg_t cur_in();
      mcfg_t c;
      c.ha = int'(cfg_hact); c.hb = int'(cfg_hblank); c.hd = int'(cfg_hsdly);
      c.hw = int'(cfg_hswid); c.hp = int'(cfg_hspol);
      c.va = int'(cfg_vact); c.vb = int'(cfg_vblank); c.vd = int'(cfg_vsdly);
      c.vw = int'(cfg_vswid); c.vp = int'(cfg_vspol);
      c.bl = int'(cfg_blank);
      return c;
   endfunction

   function automatic bit same_cfg(input mcfg_t a, input mcfg_t b);
      return a.ha == b.ha && a.hb == b.hb && a.hd == b.hd && a.hw == b.hw &&
             a.hp == b.hp && a.va == b.va && a.vb == b.vb && a.vd == b.vd &&
             a.vw == b.vw && a.vp == b.vp && a.bl == b.bl;
   endfunction

   // expected values, straight from the requirements
   function automatic int h_act_len(input mcfg_t c); return 8 * (c.ha + 1); endfunction
   function automatic int h_total(input mcfg_t c);   return 8 * (c.ha + 1) + 8 * (c.hb + 1); endfunction
   function automatic int v_act_len(input mcfg_t c); return c.va + 1; endfunction
   function automatic int v_total(input mcfg_t c);   return (c.va + 1) + (c.vb + 1); endfunction

   function automatic bit exp_hsync(input int px, input mcfg_t c);
      int b = h_act_len(c) + 8 * (c.hd + 1);
      bit on = (px >= b) && (px < b + 8 * (c.hw + 1));
      return (c.hp != 0) ? on : !on;
   endfunction

   function automatic bit exp_vsync(input int ln, input mcfg_t c);
      int b = v_act_len(c) + c.vd + 1;
      bit on = (ln >= b) && (ln < b + c.vw + 1);
      return (c.vp != 0) ? on : !on;
   endfunction

   function automatic bit exp_de(input int px, input int ln, input mcfg_t c);
      return (px < h_act_len(c)) && (ln < v_act_len(c)) && (c.bl == 0);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: got %0d expected %0d (x=%0d y=%0d)", req, what, act, exp, mx, my);
      end
   endtask

   // reference raster position and shadow configuration
   always @(posedge clk) begin
      if (!rst_n) begin
         mx  <= 0;
         my  <= 0;
         msh <= rst_cfg();
      end else if (mx == h_total(msh) - 1) begin
         mx <= 0;
         if (my == v_total(msh) - 1) begin
            my  <= 0;
            msh <= cur_in();
         end else begin
            my <= my + 1;
         end
      end else begin
         mx <= mx + 1;
      end
   end

   // cycle-level comparison at the falling edge
   always @(negedge clk) begin
      if (mon_en && !done) begin
         bit pend;
         pend = !same_cfg(cur_in(), msh);
         // R1 pixel counter, R9 when a new configuration is waiting
         chk(int'(x) == mx, pend ? "R9" : "R1", "x", int'(x), mx);
         // R2 line counter
         chk(int'(y) == my, pend ? "R9" : "R2", "y", int'(y), my);
         // R3 window with R5 polarity; R7 when blanked
         chk(hsync == exp_hsync(mx, msh), (msh.bl != 0) ? "R7" : "R3 R5", "hsync",
             int'(hsync), int'(exp_hsync(mx, msh)));
         // R4 window with R5 polarity
         chk(vsync == exp_vsync(my, msh), (msh.bl != 0) ? "R7" : "R4 R5", "vsync",
             int'(vsync), int'(exp_vsync(my, msh)));
         // R6 display enable
         chk(de == exp_de(mx, my, msh), "R6", "de", int'(de), int'(exp_de(mx, my, msh)));
         // R8 retrace status
         chk(vretrace == (my >= v_act_len(msh)), "R8", "vretrace",
             int'(vretrace), int'(my >= v_act_len(msh)));
      end
   end

   task automatic drive(input int ha, input int hb, input int hd, input int hw, input int hp,
                        input int va, input int vb, input int vd, input int vw, input int vp,
                        input int bl);
      @(negedge clk);
      #1;
      cfg_hact  = HCW'(ha); cfg_hblank = HCW'(hb); cfg_hsdly = HCW'(hd);
      cfg_hswid = HCW'(hw); cfg_hspol  = 1'(hp);
      cfg_vact  = VW'(va);  cfg_vblank = VW'(vb);  cfg_vsdly = VW'(vd);
      cfg_vswid = VW'(vw);  cfg_vspol  = 1'(vp);   cfg_blank = 1'(bl);
   endtask

   task automatic wait_cycles(input int n);
      repeat (n) @(posedge clk);
   endtask

   initial begin
      void'($urandom(32'h1A2B3C4D));
      drive(R_HACT, R_HBLANK, R_HSDLY, R_HSWID, R_HSPOL,
            R_VACT, R_VBLANK, R_VSDLY, R_VSWID, R_VSPOL, 0);
      rst_n = 1'b0;
      wait_cycles(4);
      @(negedge clk);
      // R10: reset state; position 0 is active, so de is 1 and active-high syncs are low
      chk(x == '0, "R10", "x in reset", int'(x), 0);
      chk(y == '0, "R10", "y in reset", int'(y), 0);
      chk(vretrace == 1'b0, "R10", "vretrace in reset", int'(vretrace), 0);
      chk(de == 1'b1, "R10", "de in reset", int'(de), 1);
      chk(hsync == 1'b0, "R10", "hsync in reset", int'(hsync), 0);
      chk(vsync == 1'b0, "R10", "vsync in reset", int'(vsync), 0);
      #1;
      rst_n  = 1'b1;
      mon_en = 1'b1;
      wait_cycles(600);

      // smallest geometry, low polarity: 16-pixel lines, 2-line frames
      drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      wait_cycles(400);

      // sync windows that run past the end of the line and frame
      drive(1, 0, 2, 3, 1, 2, 1, 3, 2, 1, 0);
      wait_cycles(500);

      // blank set: timing continues, de stays low (R7)
      drive(2, 1, 0, 1, 1, 3, 4, 1, 1, 0, 1);
      wait_cycles(700);
      drive(2, 1, 0, 1, 1, 3, 4, 1, 1, 0, 0);
      wait_cycles(700);

      // random configurations written at random points in the frame (R9)
      for (int i = 0; i < 40; i++) begin
         drive($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
               $urandom_range(0, 3), $urandom_range(0, 1),
               $urandom_range(0, 5), $urandom_range(0, 5), $urandom_range(0, 5),
               $urandom_range(0, 3), $urandom_range(0, 1),
               ($urandom_range(0, 7) == 0) ? 1 : 0);
         wait_cycles($urandom_range(50, 900));
      end

      wait_cycles(10);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (WATCHDOG_CYCLES) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule